// File: doc/BRIEF.md
# Bus-Attached Control Register Writer

This block is a write-only two-wire serial slave that fills a small bank of 8-bit control registers. A fast system clock oversamples the serial clock and data lines through two-flop synchronizers, and edge logic recognises START and STOP conditions. The block acknowledges only frames whose 7-bit device address has the upper five bits fixed at `00100` and the lower two bits taken from two strap pins. The write direction bit must also be set.

After the device address comes a sub-address byte that loads a 5-bit write pointer. Each following data byte is stored at the pointer, and the pointer then advances. When the pointer moves past the last register (08h) it wraps to 00h, so a long burst overwrites registers it has already written. The whole register bank is always visible on a flat parallel output. The block never drives the data line high. It only enables a pull-down during acknowledge slots.

Top module: `i2c_regwr_slave`

## Requirements
- R1: After reset all nine registers read 00h and `sda_oe` is 0.
- R2: A falling data line while the clock is high starts a new frame at any time, including during a frame (repeated START). A rising data line while the clock is high ends the frame, and the block then ignores traffic until the next START.
- R3: The first byte is received MSB first as the address `{00100, strap_hi, strap_lo}` followed by a direction bit. The block acknowledges it only when all seven address bits match and the direction bit is 0. On a mismatch it does not acknowledge, and every byte up to the next START has no effect.
- R4: A first byte with the direction bit at 1 (a read request) is not acknowledged, and no register changes until the next START.
- R5: The second byte is acknowledged and its bits 4:0 load the write pointer only if its bits 7:5 are 000. Otherwise it is not acknowledged and the rest of the frame is ignored.
- R6: Each byte after the sub-address is acknowledged and stored, MSB first, into the register the pointer selects.
- R7: After each data byte the pointer increments by one. A byte written at 08h sends the pointer to 00h, so later bytes overwrite registers 00h onward.
- R8: A data byte that arrives while the pointer is between 09h and 1Fh is acknowledged but changes no register. The pointer still increments, and 1Fh is followed by 00h.
- R9: `sda_oe` rises only after the clock falls at the end of a byte's eighth bit. It falls at the clock fall that ends the ninth (acknowledge) bit. The block has no output that drives the line high.
- R10: Register n appears on `reg_bank_o[8n+7:8n]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the wire |
| sda_oe | output | 1 | 1 enables the pull-down of the data line |
| strap_hi | input | 1 | Device address bit 1 strap |
| strap_lo | input | 1 | Device address bit 0 strap |
| reg_bank_o | output | 72 | All registers, register n at bits 8n+7:8n |

## Verification
The register-bank write strobe and the pointer wrap happen in the same system-clock cycle: the clock fall after the eighth bit of a data byte at pointer 08h both stores the byte and returns the pointer to 00h. The bench provokes this with a three-byte burst that starts at 07h. It then reads 07h, 08h and 00h on the parallel output, and the third byte must land in 00h. A second burst from 1Fh checks that a discarded byte and the natural roll of the 5-bit pointer fall together in the same way.

// File: rtl/i2c_regwr_pkg.sv
package i2c_regwr_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DEV  = 2'd1,
    PH_SUB  = 2'd2,
    PH_DAT  = 2'd3
  } phase_t;

  localparam int BYTE_W = 8;

endpackage

// File: rtl/i2c_regwr_line_sync.sv
module i2c_regwr_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic scl_meta, scl_sync, scl_prev;
  logic sda_meta, sda_sync, sda_prev;

  // Two-flop synchronizers plus one history flop per line; idle bus is high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_meta <= 1'b1;
      scl_sync <= 1'b1;
      scl_prev <= 1'b1;
      sda_meta <= 1'b1;
      sda_sync <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_meta <= scl_i;
      scl_sync <= scl_meta;
      scl_prev <= scl_sync;
      sda_meta <= sda_i;
      sda_sync <= sda_meta;
      sda_prev <= sda_sync;
    end
  end

  always_comb begin
    sda_s     = sda_sync;
    scl_rise  = scl_sync & ~scl_prev;
    scl_fall  = ~scl_sync & scl_prev;
    start_det = scl_sync & scl_prev & sda_prev & ~sda_sync;
    stop_det  = scl_sync & scl_prev & ~sda_prev & sda_sync;
  end

endmodule

// File: rtl/i2c_regwr_engine.sv
module i2c_regwr_engine
  import i2c_regwr_pkg::*;
#(
  parameter int            NUM_REGS = 9,
  parameter int            PTR_W    = 5,
  parameter logic [4:0]    DEV_HI   = 5'b00100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [1:0]       strap,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data
);

  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(NUM_REGS - 1);
  localparam logic [3:0]       BIT_ACK  = 4'd9;
  localparam logic [3:0]       BIT_FULL = 4'd8;

  phase_t              phase_q, phase_d;
  logic [3:0]          bit_q, bit_d;
  logic [BYTE_W-1:0]   shift_q, shift_d;
  logic [PTR_W-1:0]    ptr_q, ptr_d;
  logic                oe_q, oe_d;
  logic                dev_match;

  assign dev_match = (shift_q[7:1] == {DEV_HI, strap}) && !shift_q[0];

  // Next-state logic
  always_comb begin
    phase_d = phase_q;
    bit_d   = bit_q;
    shift_d = shift_q;
    ptr_d   = ptr_q;
    oe_d    = oe_q;
    wr_en   = 1'b0;
    if (start_det) begin
      phase_d = PH_DEV;
      bit_d   = '0;
      oe_d    = 1'b0;
    end else if (stop_det) begin
      phase_d = PH_IDLE;
      bit_d   = '0;
      oe_d    = 1'b0;
    end else if (phase_q != PH_IDLE) begin
      if (scl_rise && (bit_q < BIT_FULL)) begin
        shift_d = {shift_q[BYTE_W-2:0], sda_s};
        bit_d   = bit_q + 4'd1;
      end else if (scl_fall && (bit_q == BIT_FULL)) begin
        bit_d = BIT_ACK;
        case (phase_q)
          PH_DEV: begin
            if (dev_match) oe_d = 1'b1;
            else begin
              phase_d = PH_IDLE;
              bit_d   = '0;
            end
          end
          PH_SUB: begin
            if (shift_q[7:5] == 3'b000) begin
              oe_d  = 1'b1;
              ptr_d = shift_q[PTR_W-1:0];
            end else begin
              phase_d = PH_IDLE;
              bit_d   = '0;
            end
          end
          PH_DAT: begin
            oe_d = 1'b1;
            if (ptr_q <= LAST_IDX) wr_en = 1'b1;
            if (ptr_q == LAST_IDX) ptr_d = '0;
            else                   ptr_d = ptr_q + 1'b1;
          end
          default: begin
            phase_d = PH_IDLE;
            bit_d   = '0;
          end
        endcase
      end else if (scl_fall && (bit_q == BIT_ACK)) begin
        oe_d  = 1'b0;
        bit_d = '0;
        if (phase_q == PH_DEV)      phase_d = PH_SUB;
        else if (phase_q == PH_SUB) phase_d = PH_DAT;
      end
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      bit_q   <= '0;
      shift_q <= '0;
      ptr_q   <= '0;
      oe_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      bit_q   <= bit_d;
      shift_q <= shift_d;
      ptr_q   <= ptr_d;
      oe_q    <= oe_d;
    end
  end

  assign sda_oe  = oe_q;
  assign wr_addr = ptr_q;
  assign wr_data = shift_q;

  // R2
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (phase_q == PH_DEV) && (bit_q == 4'd0) && !oe_q);

  // R2
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !start_det) |=> (phase_q == PH_IDLE) && !oe_q);

  // R9
  ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> $past(scl_fall));

  // R9
  ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_q) |-> $past(scl_fall || start_det || stop_det));

  // R8
  discard_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr <= LAST_IDX));

  // R7
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (ptr_q == LAST_IDX)) |=> (ptr_q == '0));

endmodule

// File: rtl/i2c_regwr_bank.sv
module i2c_regwr_bank
  import i2c_regwr_pkg::*;
#(
  parameter int NUM_REGS = 9,
  parameter int PTR_W    = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [PTR_W-1:0]             waddr,
  input  logic [BYTE_W-1:0]            wdata,
  output logic [NUM_REGS*BYTE_W-1:0]   bank_flat
);

  logic [BYTE_W-1:0] regs_q [NUM_REGS];

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    logic hit;
    assign hit = we && (waddr == PTR_W'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs_q[gi] <= '0;
      else if (hit) regs_q[gi] <= wdata;
    end
    assign bank_flat[gi*BYTE_W +: BYTE_W] = regs_q[gi];
  end

  // R6
  bank_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (waddr < PTR_W'(NUM_REGS))) |=> (regs_q[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/i2c_regwr_slave.sv
module i2c_regwr_slave
  import i2c_regwr_pkg::*;
#(
  parameter int         NUM_REGS = 9,
  parameter int         PTR_W    = 5,
  parameter logic [4:0] DEV_HI   = 5'b00100
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       scl_i,
  input  logic                       sda_i,
  output logic                       sda_oe,
  input  logic                       strap_hi,
  input  logic                       strap_lo,
  output logic [NUM_REGS*BYTE_W-1:0] reg_bank_o
);

  logic [1:0]        rst_pipe;
  logic              rst_n_int;
  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  logic [PTR_W-1:0]  wr_addr;
  logic [BYTE_W-1:0] wr_data;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  i2c_regwr_line_sync u_sync (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_regwr_engine #(
    .NUM_REGS (NUM_REGS),
    .PTR_W    (PTR_W),
    .DEV_HI   (DEV_HI)
  ) u_engine (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .strap     ({strap_hi, strap_lo}),
    .sda_oe    (sda_oe),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
  );

  i2c_regwr_bank #(
    .NUM_REGS (NUM_REGS),
    .PTR_W    (PTR_W)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .we        (wr_en),
    .waddr     (wr_addr),
    .wdata     (wr_data),
    .bank_flat (reg_bank_o)
  );

endmodule

// File: tb/tb_i2c_regwr_slave.sv
module tb_i2c_regwr_slave;

  localparam int Q    = 10;       // quarter serial-clock period in system clocks
  localparam int NREG = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic strap_hi = 1'b1;
  logic strap_lo = 1'b0;
  logic sda_oe;
  logic sda_line;
  logic [NREG*8-1:0] bank;

  logic [7:0] model [NREG];
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;  // 50 MHz

  assign sda_line = sda_m & ~sda_oe;

  i2c_regwr_slave dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl),
    .sda_i      (sda_line),
    .sda_oe     (sda_oe),
    .strap_hi   (strap_hi),
    .strap_lo   (strap_lo),
    .reg_bank_o (bank)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      fails  = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q);
    scl = 1'b1;   wq(Q);
    sda_m = 1'b0; wq(Q);
    scl = 1'b0;   wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl = 1'b1;   wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q);
      scl = 1'b1;   wq(2*Q);
      scl = 1'b0;   wq(Q);
    end
    sda_m = 1'b1; wq(Q);
    scl = 1'b1;   wq(Q);
    ack = ~sda_line;
    wq(Q);
    scl = 1'b0;   wq(Q);
  endtask

  // Full write frame with up to three data bytes; acks and model from the requirements.
  task automatic xfer(input logic [7:0] dev, input logic [7:0] sub, input int n,
                      input logic [23:0] dats);
    logic ack;
    logic dev_ok, sub_ok;
    logic [4:0] ptr;
    dev_ok = (dev == {5'b00100, strap_hi, strap_lo, 1'b0});
    sub_ok = dev_ok && (sub[7:5] == 3'b000);
    ptr    = sub[4:0];
    bus_start();
    send_byte(dev, ack);
    check("R3 R4 dev ack", 32'(ack), 32'(dev_ok));
    check("R9 ack released", 32'(sda_oe), 32'h0);
    send_byte(sub, ack);
    check("R5 sub ack", 32'(ack), 32'(sub_ok));
    for (int k = 0; k < n; k++) begin
      send_byte(dats[23-8*k -: 8], ack);
      check("R6 data ack", 32'(ack), 32'(sub_ok));
      if (sub_ok) begin
        if (ptr <= 5'd8) model[ptr] = dats[23-8*k -: 8];
        ptr = (ptr == 5'd8) ? 5'd0 : ptr + 5'd1;
      end
    end
    bus_stop();
    wq(Q);
  endtask

  task automatic cmp_bank(input string req);
    for (int i = 0; i < NREG; i++)
      check(req, 32'(bank[i*8 +: 8]), 32'(model[i]));
  endtask

  // {device byte, sub-address, data}; strap = 2'b10 so the write address byte is 24h
  localparam logic [23:0] VEC [8] = '{
    {8'h24, 8'h00, 8'h1E},   // plain write
    {8'h24, 8'h03, 8'hC4},   // MSB-first pattern
    {8'h24, 8'h08, 8'h01},   // last register
    {8'h26, 8'h01, 8'h77},   // wrong strap bits
    {8'h25, 8'h02, 8'h11},   // read request
    {8'hA4, 8'h02, 8'h12},   // wrong fixed bits
    {8'h24, 8'h0A, 8'h99},   // out of map, discarded
    {8'h24, 8'hE1, 8'h55}    // sub-address upper bits set
  };

  initial begin
    logic ack;
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    wq(5);
    rst_n = 1'b1;
    wq(5);

    // R1 reset state
    check("R1 sda_oe", 32'(sda_oe), 32'h0);
    cmp_bank("R1 reset bank");

    // Vector table (R3 R4 R5 R6 R8 R10)
    for (int v = 0; v < 8; v++) begin
      xfer(VEC[v][23:16], VEC[v][15:8], 1, {VEC[v][7:0], 16'h0});
      cmp_bank("R10 table bank");
    end

    // R7 burst over the end of the map: 07h, 08h, then wrap to 00h
    xfer(8'h24, 8'h07, 3, 24'h112233);
    check("R7 reg07", 32'(bank[7*8 +: 8]), 32'h11);
    check("R7 reg08", 32'(bank[8*8 +: 8]), 32'h22);
    check("R7 wrap reg00", 32'(bank[0 +: 8]), 32'h33);

    // R8 pointer 1Fh discards, then rolls to 00h
    xfer(8'h24, 8'h1F, 2, 24'h444500);
    check("R8 roll reg00", 32'(bank[0 +: 8]), 32'h45);
    cmp_bank("R8 bank");

    // R2 repeated START restarts address reception
    bus_start();
    send_byte(8'h24, ack);
    send_byte(8'h04, ack);
    xfer(8'h24, 8'h05, 1, 24'h660000);
    check("R2 reg05", 32'(bank[5*8 +: 8]), 32'h66);
    check("R2 reg04 untouched", 32'(bank[4*8 +: 8]), 32'h00);

    // R2 bytes after STOP without START are ignored
    send_byte(8'h24, ack);
    check("R2 no ack after stop", 32'(ack), 32'h0);
    send_byte(8'h06, ack);
    send_byte(8'hAB, ack);
    cmp_bank("R2 idle bank");

    // R3 straps change the address
    strap_hi = 1'b0; strap_lo = 1'b1;
    xfer(8'h22, 8'h02, 1, 24'h5A0000);
    xfer(8'h24, 8'h02, 1, 24'hEE0000);
    cmp_bank("R3 strap bank");

    // R9 line released while idle
    check("R9 idle oe", 32'(sda_oe), 32'h0);

    // R1 reset mid-life clears the bank
    rst_n = 1'b0; wq(3); rst_n = 1'b1; wq(5);
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    cmp_bank("R1 re-reset bank");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule